// File: doc/BRIEF.md
# Block Move Transfer Engine

This block copies a run of bytes from one place in a 24-bit address space to another through a single byte-wide memory port. Each address is an 8-bit bank in the top bits and a 16-bit offset below it. A single start pulse hands the engine its operands: a source bank, a destination bank, a starting source offset, a starting destination offset, a 16-bit count, an index-width flag and a direction select.

For every byte the engine first reads at {source bank, source offset} and then writes that byte at {destination bank, destination offset}. After the write it steps both offsets one place in the selected direction and decrements the count. The run ends when the count steps from zero down to all ones, so a run moves one byte more than the count it was given. The live offsets and the count are always visible on the outputs. When the done pulse appears they hold the final values, and the caller can reload them from there.

Top module: `blkmove_engine`

## Requirements
- R1: During and straight after reset, busy, done and memWe are all 0.
- R2: A start pulse seen while the engine is idle latches every operand. In the cycle after that edge, busy is 1, memWe is 0 and memAddr is {srcBank, effective X}.
- R3: Each byte takes two cycles. In the read cycle memWe=0 and memAddr={source bank, X}. In the write cycle memWe=1, memAddr={destination bank, Y} and memWdata equals the byte returned in the read cycle.
- R4: A run moves exactly countInit+1 bytes, so a count of 0 moves one byte.
- R5: With decMode=0, X and Y each rise by 1 after every byte. With decMode=1 they each fall by 1.
- R6: With narrowIdx=1, bits 15:8 of X and Y are 0 from the moment of the latch. Stepping then wraps within bits 7:0, so $FF+1 gives $00 and $00-1 gives $FF.
- R7: With narrowIdx=0, offsets wrap within 16 bits ($FFFF+1 gives $0000 and $0000-1 gives $FFFF). The bank part of memAddr never changes during a run.
- R8: done is 1 for exactly one cycle, directly after the last write cycle. In that cycle busy=0, countOut=$FFFF, and xOut and yOut hold the offsets one step past the last byte. In the following cycle done is 0.
- R9: A start pulse while a run is in progress is ignored. The run continues with its latched banks, offsets and count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run; honoured only when idle |
| srcBank | input | 8 | Source bank operand |
| dstBank | input | 8 | Destination bank operand |
| xInit | input | 16 | Starting source offset |
| yInit | input | 16 | Starting destination offset |
| countInit | input | 16 | Byte count minus one |
| narrowIdx | input | 1 | 1 = offsets are 8 bits wide |
| decMode | input | 1 | 1 = offsets count downward |
| memRdata | input | 8 | Read data, valid in the same cycle as memAddr |
| memAddr | output | 24 | Memory address {bank, offset} |
| memWe | output | 1 | Write strobe |
| memWdata | output | 8 | Write data |
| busy | output | 1 | A run is in its read/write cycles |
| done | output | 1 | One-cycle end-of-run pulse |
| xOut | output | 16 | Current source offset |
| yOut | output | 16 | Current destination offset |
| countOut | output | 16 | Current count |

## Verification
The bench drives runs that cross offset $FFFF in both directions and checks that memAddr keeps its bank. A design that carried the offset into the bank would show up at the wrap. Narrow-index runs start with nonzero high bytes and then step across $FF. An engine that masked only at the latch, or never masked at all, would produce wrong addresses or wrong final offsets. A run with a count of 0 must move exactly one byte, which exposes an off-by-one in the end test. A start pulse injected mid-run with different operands must leave the copy untouched, so an engine that reloaded would write to the wrong addresses.

// File: rtl/blkmove_pkg.sv
package blkmove_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2,
    ST_FIN  = 2'd3
  } mvState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // latch operands
    logic rdPhase;  // read cycle: source address out, capture data
    logic wrPhase;  // write cycle: destination address out, then step
  } mvStrobe_t;

endpackage

// File: rtl/blkmove_ctrl.sv
module blkmove_ctrl
  import blkmove_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      lastByte,
  output mvStrobe_t str,
  output logic      busy,
  output logic      done
);

  mvState_t state, stateNxt;

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE: if (start) stateNxt = ST_RD;
      ST_RD:   stateNxt = ST_WR;
      ST_WR:   stateNxt = lastByte ? ST_FIN : ST_RD;
      ST_FIN:  stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    str.load    = (state == ST_IDLE) && start;
    str.rdPhase = (state == ST_RD);
    str.wrPhase = (state == ST_WR);
  end

  assign busy = (state == ST_RD) || (state == ST_WR);
  assign done = (state == ST_FIN);

  // R3
  wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rstN)
    str.wrPhase |-> $past(str.rdPhase));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

  // R2
  load_to_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    str.load |=> str.rdPhase);

endmodule

// File: rtl/blkmove_dp.sv
module blkmove_dp
  import blkmove_pkg::*;
#(
  parameter int OFS_W  = 16,
  parameter int BANK_W = 8,
  parameter int DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  mvStrobe_t               str,
  input  logic [BANK_W-1:0]       srcBank,
  input  logic [BANK_W-1:0]       dstBank,
  input  logic [OFS_W-1:0]        xInit,
  input  logic [OFS_W-1:0]        yInit,
  input  logic [OFS_W-1:0]        countInit,
  input  logic                    narrowIdx,
  input  logic                    decMode,
  input  logic [DATA_W-1:0]       memRdata,
  output logic [BANK_W+OFS_W-1:0] memAddr,
  output logic                    memWe,
  output logic [DATA_W-1:0]       memWdata,
  output logic [OFS_W-1:0]        xOut,
  output logic [OFS_W-1:0]        yOut,
  output logic [OFS_W-1:0]        countOut,
  output logic                    lastByte
);

  localparam int NAR_W = OFS_W / 2;
  localparam logic [OFS_W-1:0] LOW_MASK = {{(OFS_W-NAR_W){1'b0}}, {NAR_W{1'b1}}};

  logic [BANK_W-1:0] srcBankR, dstBankR;
  logic [OFS_W-1:0]  xR, yR, cntR;
  logic              narrowR, decR;
  logic [DATA_W-1:0] dataR;

  function automatic logic [OFS_W-1:0] stepOfs(input logic [OFS_W-1:0] ofs,
                                               input logic nar, input logic dn);
    logic [OFS_W-1:0] nxt;
    nxt = dn ? (ofs - 1'b1) : (ofs + 1'b1);
    return nar ? (nxt & LOW_MASK) : nxt;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcBankR <= '0;
      dstBankR <= '0;
      xR       <= '0;
      yR       <= '0;
      cntR     <= '0;
      narrowR  <= 1'b0;
      decR     <= 1'b0;
      dataR    <= '0;
    end else begin
      if (str.load) begin
        srcBankR <= srcBank;
        dstBankR <= dstBank;
        xR       <= narrowIdx ? (xInit & LOW_MASK) : xInit;
        yR       <= narrowIdx ? (yInit & LOW_MASK) : yInit;
        cntR     <= countInit;
        narrowR  <= narrowIdx;
        decR     <= decMode;
      end
      if (str.rdPhase) dataR <= memRdata;
      if (str.wrPhase) begin
        xR   <= stepOfs(xR, narrowR, decR);
        yR   <= stepOfs(yR, narrowR, decR);
        cntR <= cntR - 1'b1;
      end
    end
  end

  assign memAddr  = str.wrPhase ? {dstBankR, yR} : {srcBankR, xR};
  assign memWe    = str.wrPhase;
  assign memWdata = dataR;
  assign xOut     = xR;
  assign yOut     = yR;
  assign countOut = cntR;
  assign lastByte = (cntR == '0);

  // R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    str.wrPhase |=> (cntR == $past(cntR) - 1'b1));

  // R6
  narrow_hi_chk: assert property (@(posedge clk) disable iff (!rstN)
    narrowR |-> ((xR & ~LOW_MASK) == '0) && ((yR & ~LOW_MASK) == '0));

  // R5
  ofs_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!str.wrPhase && !str.load) |=> ($stable(xR) && $stable(yR)));

  // R9
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !str.load |=> ($stable(srcBankR) && $stable(dstBankR) && $stable(decR)));

endmodule

// File: rtl/blkmove_engine.sv
module blkmove_engine
  import blkmove_pkg::*;
#(
  parameter int OFS_W  = 16,
  parameter int BANK_W = 8,
  parameter int DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic [BANK_W-1:0]       srcBank,
  input  logic [BANK_W-1:0]       dstBank,
  input  logic [OFS_W-1:0]        xInit,
  input  logic [OFS_W-1:0]        yInit,
  input  logic [OFS_W-1:0]        countInit,
  input  logic                    narrowIdx,
  input  logic                    decMode,
  input  logic [DATA_W-1:0]       memRdata,
  output logic [BANK_W+OFS_W-1:0] memAddr,
  output logic                    memWe,
  output logic [DATA_W-1:0]       memWdata,
  output logic                    busy,
  output logic                    done,
  output logic [OFS_W-1:0]        xOut,
  output logic [OFS_W-1:0]        yOut,
  output logic [OFS_W-1:0]        countOut
);

  mvStrobe_t str;
  logic      lastByte;

  blkmove_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .lastByte (lastByte),
    .str      (str),
    .busy     (busy),
    .done     (done)
  );

  blkmove_dp #(
    .OFS_W  (OFS_W),
    .BANK_W (BANK_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .str       (str),
    .srcBank   (srcBank),
    .dstBank   (dstBank),
    .xInit     (xInit),
    .yInit     (yInit),
    .countInit (countInit),
    .narrowIdx (narrowIdx),
    .decMode   (decMode),
    .memRdata  (memRdata),
    .memAddr   (memAddr),
    .memWe     (memWe),
    .memWdata  (memWdata),
    .xOut      (xOut),
    .yOut      (yOut),
    .countOut  (countOut),
    .lastByte  (lastByte)
  );

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memWe);

endmodule

// File: tb/blkmove_engine_tb.sv
`timescale 1ns/1ps
module blkmove_engine_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  srcBank = '0, dstBank = '0;
  logic [15:0] xInit = '0, yInit = '0, countInit = '0;
  logic        narrowIdx = 1'b0, decMode = 1'b0;
  logic [7:0]  memRdata;
  logic [23:0] memAddr;
  logic        memWe;
  logic [7:0]  memWdata;
  logic        busy, done;
  logic [15:0] xOut, yOut, countOut;

  always #10 clk = ~clk;

  function automatic logic [7:0] pat(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
  endfunction

  assign memRdata = pat(memAddr);

  blkmove_engine u_dut (
    .clk(clk), .rstN(rstN), .start(start), .srcBank(srcBank), .dstBank(dstBank),
    .xInit(xInit), .yInit(yInit), .countInit(countInit), .narrowIdx(narrowIdx),
    .decMode(decMode), .memRdata(memRdata), .memAddr(memAddr), .memWe(memWe),
    .memWdata(memWdata), .busy(busy), .done(done), .xOut(xOut), .yOut(yOut),
    .countOut(countOut)
  );

  typedef struct packed {
    logic [7:0]  sb;
    logic [7:0]  db;
    logic [15:0] x;
    logic [15:0] y;
    logic [15:0] c;
    logic        nar;
    logic        dec;
    logic [15:0] ex;
    logic [15:0] ey;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{8'h12, 8'h34, 16'h0100, 16'h0200, 16'h0003, 1'b0, 1'b0, 16'h0104, 16'h0204},
    '{8'h01, 8'h02, 16'h0010, 16'h0020, 16'h0002, 1'b0, 1'b1, 16'h000D, 16'h001D},
    '{8'h05, 8'h06, 16'h1234, 16'h4321, 16'h0000, 1'b0, 1'b0, 16'h1235, 16'h4322},
    '{8'h07, 8'h08, 16'hABFE, 16'h12FF, 16'h0002, 1'b1, 1'b0, 16'h0001, 16'h0002},
    '{8'h09, 8'h0A, 16'hFFFF, 16'hFFFE, 16'h0002, 1'b0, 1'b0, 16'h0002, 16'h0001},
    '{8'h0B, 8'h0C, 16'h5501, 16'h7700, 16'h0001, 1'b1, 1'b1, 16'h00FF, 16'h00FE},
    '{8'h0D, 8'h0E, 16'h0000, 16'h0001, 16'h0001, 1'b0, 1'b1, 16'hFFFE, 16'hFFFF}
  };

  int total = 0;
  int bad = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] nxt(input logic [15:0] o, input logic nar,
                                      input logic dn);
    logic [15:0] r;
    r = dn ? o - 16'd1 : o + 16'd1;
    if (nar) r[15:8] = 8'h00;
    return r;
  endfunction

  task automatic runMove(input vec_t v, input bit inject);
    logic [15:0] ex, ey;
    int  writes;
    bit  seen;
    writes = 0;
    seen = 1'b0;
    @(negedge clk);
    srcBank = v.sb; dstBank = v.db; xInit = v.x; yInit = v.y;
    countInit = v.c; narrowIdx = v.nar; decMode = v.dec; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    ex = v.nar ? {8'h00, v.x[7:0]} : v.x;
    ey = v.nar ? {8'h00, v.y[7:0]} : v.y;
    // R2: first cycle after the start edge is a read at the source
    chk(busy && !memWe && memAddr == {v.sb, ex}, "R2 first read",
        {7'd0, busy, memAddr}, {8'h01, v.sb, ex});
    for (int cyc = 0; cyc < 4 * (int'(v.c) + 1) + 8 && !seen; cyc++) begin
      if (done) begin
        seen = 1'b1;
        chk(writes == int'(v.c) + 1, "R4 byte count", writes, int'(v.c) + 1);
        chk(countOut == 16'hFFFF && !busy, "R8 final count", {15'd0, busy, countOut},
            32'h0000FFFF);
        chk(xOut == v.ex && xOut == ex, "R5 R6 R7 final X", xOut, v.ex);
        chk(yOut == v.ey && yOut == ey, "R5 R6 R7 final Y", yOut, v.ey);
      end else if (memWe) begin
        chk(memAddr == {v.db, ey}, "R3 R7 write address", memAddr, {v.db, ey});
        chk(memWdata == pat({v.sb, ex}), "R3 write data", memWdata, pat({v.sb, ex}));
        writes++;
        ex = nxt(ex, v.nar, v.dec);
        ey = nxt(ey, v.nar, v.dec);
      end else begin
        chk(busy && memAddr == {v.sb, ex}, "R3 R7 read address", memAddr, {v.sb, ex});
      end
      // R9: stray start with other operands in the middle of the run
      if (inject && cyc == 2) begin
        srcBank = ~v.sb; xInit = 16'h7777; countInit = 16'h0040; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    if (!seen) chk(1'b0, "R8 done never seen", 0, 1);
    else chk(!done && !busy, "R8 done lasts one cycle", {done, busy}, 0);
  endtask

  initial begin
    #(4_000_000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1: outputs quiet in reset
    chk(!busy && !done && !memWe, "R1 in reset", {busy, done, memWe}, 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !memWe, "R1 after reset", {busy, done, memWe}, 0);

    for (int i = 0; i < NVEC; i++) runMove(VECS[i], 1'b0);

    // R9: start ignored mid-run
    runMove(VECS[0], 1'b1);
    // R4: single byte again after a run, checks restart from idle
    runMove(VECS[2], 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule